// File: doc/BRIEF.md
# Staged Ten-Bit PWM With Byte Register Access

This block produces a pulse-width modulated output whose duty is a 10-bit value from 0 to 1023. A host sets the duty through a byte-wide write port, one byte at a time. The two upper duty bits go into a high-byte register and the eight lower bits into a low-byte register. Writing the high byte only stages its bits. Writing the low byte commits the full staged value to the generator in one step, so the generator never runs on a half-updated duty.

A persistence input decides whether a committed value also becomes the startup default. A shadow register stands in for non-volatile storage. It is not cleared by the synchronous reset, and a reset loads its content into the generator and into the staged registers. If the persistence input was never high during a low-byte write, the shadow holds zero, so the duty after reset is zero. The generator counts over 1024 steps. The output is high while the count is below the active duty. A committed duty takes effect only when the counter wraps, so every period is whole.

Top module: `pwm_stage`

## Requirements
- R1: While the persistence input has never been high during a low-byte write, a reset leaves the active duty at zero: pwm_out stays low and both read-back bytes are 0.
- R2: A write to the high-byte address (HI_ADDR, default 0) alone does not change the active duty.
- R3: A write to the low-byte address (LO_ADDR, default 1) commits {staged high bits, written byte} as the new duty. In steady state pwm_out is then high for exactly that many cycles in every 1024 consecutive cycles.
- R4: Only bits 1:0 of a high-byte write are kept, so the duty never exceeds 0x3FF, and rd_hi bits 7:2 read 0.
- R5: rd_hi returns the staged upper bits and rd_lo the staged lower byte. A high-byte write shows on rd_hi in the next cycle, before any low-byte write.
- R6: A duty of 0 gives a constant low output. A duty of 1023 gives 1023 high cycles in each 1024.
- R7: The active duty changes only at a counter wrap, so rising edges of pwm_out occur only at the start of a period, a whole multiple of 1024 cycles apart.
- R8: A low-byte write made while persist is 1 also stores the committed value in the shadow. A later reset loads that value as the active duty and as the read-back value.
- R9: A low-byte write made while persist is 0 changes the active duty but leaves the shadow unchanged, so a later reset restores the earlier stored value.
- R10: A high-byte write alone does not update the shadow, even while persist is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the shadow value |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Write data |
| persist | input | 1 | When 1, a low-byte write also updates the startup value |
| pwm_out | output | 1 | PWM output |
| rd_hi | output | 8 | Staged upper duty bits, zero-extended |
| rd_lo | output | 8 | Staged lower duty byte |

## Verification
The checker tests on every cycle the staging rules: a high-byte write leaves the pending duty alone, and a low-byte write commits the joined value. It also tests that the shadow changes only on a low-byte write made with persist set, that the active duty moves only at a wrap, and that the output rises only at count zero. Only the bench scenarios can show the duty as a high-cycle count per period, the read-back contents, and values surviving or being cleared across a reset after a sequence of persist and non-persist writes.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;
    localparam int DUTY_W  = 10;
    localparam int BYTE_W  = 8;
    localparam int HI_BITS = DUTY_W - BYTE_W;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2
    } byte_sel_e;

    typedef logic [DUTY_W-1:0] duty_t;

    function automatic logic [HI_BITS-1:0] hi_field(input logic [BYTE_W-1:0] b);
        return b[HI_BITS-1:0];
    endfunction

    function automatic duty_t join_duty(input logic [HI_BITS-1:0] hi,
                                        input logic [BYTE_W-1:0] lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/pwm_stage_decode.sv
module pwm_stage_decode
    import pwm_stage_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = '0,
    parameter logic [ADDR_W-1:0] LO_ADDR = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output byte_sel_e         sel
);
    always_comb begin
        sel = SEL_NONE;
        if (wr_en) begin
            if (wr_addr == HI_ADDR)      sel = SEL_HI;
            else if (wr_addr == LO_ADDR) sel = SEL_LO;
        end
    end
endmodule

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs
    import pwm_stage_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  byte_sel_e         sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              persist,
    output duty_t             staged,
    output duty_t             pend,
    output duty_t             shadow
);
    duty_t staged_q;
    duty_t pend_q;
    duty_t shadow_q = '0;
    duty_t commit_val;

    assign commit_val = join_duty(staged_q[DUTY_W-1:BYTE_W], wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= shadow_q;
            pend_q   <= shadow_q;
        end else begin
            case (sel)
                SEL_HI: staged_q[DUTY_W-1:BYTE_W] <= hi_field(wr_data);
                SEL_LO: begin
                    staged_q[BYTE_W-1:0] <= wr_data;
                    pend_q               <= commit_val;
                end
                default: ;
            endcase
        end
    end

    // stands in for non-volatile storage: untouched by reset
    always_ff @(posedge clk) begin
        if (!rst && sel == SEL_LO && persist)
            shadow_q <= commit_val;
    end

    assign staged = staged_q;
    assign pend   = pend_q;
    assign shadow = shadow_q;
endmodule

// File: rtl/pwm_stage_gen.sv
module pwm_stage_gen
    import pwm_stage_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  duty_t duty_rst,
    input  duty_t duty_next,
    output logic  pwm_o,
    output duty_t cnt_o,
    output duty_t duty_o
);
    duty_t cnt_q;
    duty_t duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            duty_q <= duty_rst;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '1)
                duty_q <= duty_next;
        end
    end

    assign pwm_o  = (cnt_q < duty_q);
    assign cnt_o  = cnt_q;
    assign duty_o = duty_q;
endmodule

// File: rtl/pwm_stage.sv
module pwm_stage
    import pwm_stage_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = '0,
    parameter logic [ADDR_W-1:0] LO_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              persist,
    output logic              pwm_out,
    output logic [7:0]        rd_hi,
    output logic [7:0]        rd_lo
);
    byte_sel_e sel;
    duty_t     staged;
    duty_t     pend;
    duty_t     shadow;
    duty_t     cnt;
    duty_t     duty_act;

    pwm_stage_decode #(
        .ADDR_W (ADDR_W),
        .HI_ADDR(HI_ADDR),
        .LO_ADDR(LO_ADDR)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .sel    (sel)
    );

    pwm_stage_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .wr_data(wr_data),
        .persist(persist),
        .staged (staged),
        .pend   (pend),
        .shadow (shadow)
    );

    pwm_stage_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .duty_rst (shadow),
        .duty_next(pend),
        .pwm_o    (pwm_out),
        .cnt_o    (cnt),
        .duty_o   (duty_act)
    );

    assign rd_hi = {{(BYTE_W-HI_BITS){1'b0}}, staged[DUTY_W-1:BYTE_W]};
    assign rd_lo = staged[BYTE_W-1:0];
endmodule

// File: rtl/pwm_stage_chk.sv
module pwm_stage_chk
    import pwm_stage_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = '0,
    parameter logic [ADDR_W-1:0] LO_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              persist,
    input logic              pwm_out,
    input logic [7:0]        rd_hi,
    input duty_t             staged,
    input duty_t             pend,
    input duty_t             shadow,
    input duty_t             cnt,
    input duty_t             duty_act
);
    logic hi_wr;
    logic lo_wr;
    logic run_q;

    assign hi_wr = wr_en && (wr_addr == HI_ADDR);
    assign lo_wr = wr_en && (wr_addr == LO_ADDR);

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= 1'b1;
    end

    // R1
    reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (duty_act == shadow && cnt == '0 && staged == shadow));

    // R2
    hi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> $stable(pend));

    // R3
    lo_commit_chk: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> pend == {$past(staged[DUTY_W-1:BYTE_W]), $past(wr_data)});

    // R5
    hi_readback_chk: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> rd_hi == {6'b0, $past(wr_data[1:0])});

    // R7
    duty_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !$stable(duty_act)) |-> $past(cnt) == '1);

    // R7
    rise_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $rose(pwm_out)) |-> cnt == '0);

    // R8
    shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_wr && persist) |=> shadow == pend);

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(lo_wr && persist) |=> $stable(shadow));
endmodule

bind pwm_stage pwm_stage_chk #(
    .ADDR_W (ADDR_W),
    .HI_ADDR(HI_ADDR),
    .LO_ADDR(LO_ADDR)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .persist (persist),
    .pwm_out (pwm_out),
    .rd_hi   (rd_hi),
    .staged  (staged),
    .pend    (pend),
    .shadow  (shadow),
    .cnt     (cnt),
    .duty_act(duty_act)
);

// File: tb/tb_pwm_stage.sv
module tb_pwm_stage;
    localparam int PERIOD = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       persist = 1'b0;
    logic       pwm_out;
    logic [7:0] rd_hi;
    logic [7:0] rd_lo;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    longint last_rise = -1;
    int bad_gaps = 0;
    int rises = 0;
    logic prev_pwm = 1'b0;
    logic done = 1'b0;

    pwm_stage dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .persist(persist), .pwm_out(pwm_out),
        .rd_hi(rd_hi), .rd_lo(rd_lo)
    );

    always #10 clk = ~clk;

    // R7 background: rising edges spaced by whole periods
    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_pwm <= pwm_out;
        if (rst) begin
            last_rise <= -1;
        end else if (pwm_out && !prev_pwm) begin
            rises <= rises + 1;
            if (last_rise >= 0 && ((cyc - last_rise) % PERIOD) != 0)
                bad_gaps <= bad_gaps + 1;
            last_rise <= cyc;
        end
    end

    function automatic int exp_duty(input logic [7:0] hi, input logic [7:0] lo);
        return int'({hi[1:0], lo});
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // settle past the next wrap, then count highs over one full period
    task automatic measure(input string req, input int exp);
        int hc;
        hc = 0;
        repeat (PERIOD + 8) @(negedge clk);
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (pwm_out) hc++;
        end
        check(req, hc, exp);
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 rd_hi", rd_hi, 0);
        check("R1 rd_lo", rd_lo, 0);
        check("R1 pwm", pwm_out, 0);
        measure("R1 high count", 0);

        // R5 / R2
        wr(8'd0, 8'h01);
        check("R5 rd_hi staged", rd_hi, 1);
        measure("R2 high byte alone", 0);
        // R3
        wr(8'd1, 8'h23);
        check("R3 rd_lo", rd_lo, 8'h23);
        measure("R3 commit", 291);
        // R4
        wr(8'd0, 8'hFE);
        check("R4 rd_hi masked", rd_hi, 2);
        measure("R2 still old duty", 291);
        wr(8'd1, 8'hFF);
        measure("R4 masked duty", 767);
        // R6
        wr(8'd0, 8'hFF);
        wr(8'd1, 8'hFF);
        check("R4 rd_hi max", rd_hi, 3);
        measure("R6 full duty", 1023);
        wr(8'd0, 8'h00);
        wr(8'd1, 8'h00);
        measure("R6 zero duty", 0);

        // R3 / R4 random
        for (int k = 0; k < 10; k++) begin
            logic [7:0] h, l;
            h = 8'($urandom);
            l = 8'($urandom);
            wr(8'd0, h);
            wr(8'd1, l);
            check("R4 rand rd_hi", rd_hi, int'(h[1:0]));
            check("R5 rand rd_lo", rd_lo, int'(l));
            measure("R3 rand duty", exp_duty(h, l));
        end

        // R8 / R9
        persist = 1'b1;
        wr(8'd0, 8'h02);
        wr(8'd1, 8'h10);
        persist = 1'b0;
        wr(8'd0, 8'h00);
        wr(8'd1, 8'h40);
        measure("R9 active after non-persist write", 64);
        do_reset();
        @(negedge clk);
        check("R8 rd_hi after reset", rd_hi, 2);
        check("R8 rd_lo after reset", rd_lo, 8'h10);
        measure("R9 reset restores stored", 528);

        // R10
        persist = 1'b1;
        wr(8'd0, 8'h03);
        persist = 1'b0;
        do_reset();
        @(negedge clk);
        check("R10 rd_hi after reset", rd_hi, 2);
        measure("R10 stored unchanged", 528);

        @(negedge clk);
        check("R7 rise spacing", bad_gaps, 0);
        check("R7 rises seen", (rises > 20) ? 1 : 0, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule